// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block sits beside an I2C slave controller and decides whether the first byte after each START (or repeated START) is addressed to this device. The controller supplies a one-cycle START indication and a one-cycle strobe with each received byte. The block compares the first byte of each transfer against a programmable 7-bit own address and against the general call byte. On a hit it raises a one-cycle match pulse, which the controller uses to decide whether to acknowledge, and it sets sticky status flags.

Software reaches the block through a small register port. One register holds the own address and a format bit. When the format bit selects clocked synchronous serial operation, address recognition is off. A second register exposes the two flags. A flag is cleared only when software writes 0 to it after it has read that flag as 1, so a flag that sets between the read and the write is not lost.

Top module: `i2c_addr_recog`

## Requirements
- R1: While `rst` is high and on the first cycle after it, the address register reads 0x00 and `flag_addr`, `flag_gc`, `match_pulse` and `rd_data` are 0.
- R2: A write with `reg_sel`=0 stores `wr_data` in the address register: bits 7..1 are the own address and bit 0 is the format bit (0 = I2C, 1 = clocked synchronous). A read with `reg_sel`=0 returns the register on `rd_data` one cycle later. `rd_data` is 0 in cycles that follow no read.
- R3: Only the first byte strobe after a START is compared. Later bytes never change flags or pulse. A new START re-arms comparison. A byte strobe in the same cycle as a START is ignored, and comparison stays armed.
- R4: When the compared byte's bits 7..1 equal the own address, with `slv_rx_mode`=1 and format bit 0, `flag_addr` is 1 and `match_pulse` is 1 for exactly one cycle, starting in the cycle after the strobe. Bit 0 of the byte (R/W) is not compared.
- R5: A compared byte of 0x00 is a general call: it sets both `flag_gc` and `flag_addr` and pulses `match_pulse`. A byte of 0x01 is not a general call.
- R6: With format bit 1 or `slv_rx_mode`=0, a compared byte sets no flag and gives no pulse.
- R7: A read with `reg_sel`=1 returns the status byte one cycle later: bit 1 = `flag_addr`, bit 0 = `flag_gc`, other bits 0.
- R8: A status write (`reg_sel`=1) with a flag's bit at 0 clears that flag only if the flag was read as 1 by an earlier status read. Otherwise the flag stays set.
- R9: A status write with a flag's bit at 1 leaves that flag unchanged. A set condition in the same cycle as a valid clearing write wins, and the flag stays 1.
- R10: The read-as-1 permission of a flag is consumed by the next status write of any value. A later write of 0 without a new read does not clear the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_det | input | 1 | One-cycle START / repeated START indication |
| byte_vld | input | 1 | One-cycle strobe for a received byte |
| byte_data | input | 8 | Received byte, bit 0 is R/W |
| slv_rx_mode | input | 1 | Controller is in slave receive mode |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 1 | 0 = address register, 1 = status register |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Registered read data |
| flag_addr | output | 1 | Address-recognized flag (sticky) |
| flag_gc | output | 1 | General-call flag (sticky) |
| match_pulse | output | 1 | One-cycle match indication to the controller |

## Verification
The first byte is tried with the own address with both R/W values, with a mismatching address, with 0x00 and with 0x01. This separates an own match from a general call and shows that the R/W bit is masked only for the own-address compare. Second bytes carrying the own address, a START coinciding with a byte, and repeated STARTs show that only the first frame counts. Clearing is tried without a prior read, after a write of 1 that uses up the read permission, and in the same cycle as a new match, so the read-then-write rule and set priority are told apart from a plain write-0 clear. A long mixed stretch of random traffic is then compared clock by clock against a behavioural model.

// File: rtl/i2c_ar_pkg.sv
package i2c_ar_pkg;
  localparam int BYTE_W    = 8;
  localparam int ADDR_W    = BYTE_W - 1;
  localparam int NUM_FLAGS = 2;
  // status bit positions (software decodes them)
  localparam int ST_GC_BIT   = 0;
  localparam int ST_ADDR_BIT = 1;
  localparam int FMT_BIT     = 0;

  typedef enum logic {
    SEL_ADDR = 1'b0,
    SEL_STAT = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/i2c_ar_frame.sv
module i2c_ar_frame #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_det,
  input  logic          byte_vld,
  input  logic [BW-1:0] byte_data,
  input  logic [BW-2:0] own_addr,
  input  logic          fmt_sync,
  input  logic          slv_rx_mode,
  output logic          hit_own,
  output logic          hit_gc
);
  logic first_q;
  logic eval;

  always_ff @(posedge clk) begin
    if (rst)            first_q <= 1'b0;
    else if (start_det) first_q <= 1'b1;
    else if (byte_vld)  first_q <= 1'b0;
  end

  always_comb begin
    eval    = byte_vld && first_q && !start_det && !fmt_sync && slv_rx_mode;
    hit_own = eval && (byte_data[BW-1:1] == own_addr);
    hit_gc  = eval && (byte_data == '0);
  end
endmodule

// File: rtl/i2c_ar_flag.sv
module i2c_ar_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_req,
  input  logic stat_rd,
  input  logic stat_wr,
  input  logic wr_bit,
  output logic flag
);
  logic armed_q;
  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (set_req)
        flag_q <= 1'b1;
      else if (stat_wr && !wr_bit && armed_q)
        flag_q <= 1'b0;

      if (!flag_q)      armed_q <= 1'b0;
      else if (stat_wr) armed_q <= 1'b0;
      else if (stat_rd) armed_q <= 1'b1;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/i2c_ar_regs.sv
module i2c_ar_regs #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic          reg_sel,
  input  logic [BW-1:0] wr_data,
  input  logic [BW-1:0] stat_vec,
  output logic [BW-1:0] own_reg,
  output logic [BW-1:0] rd_data
);
  import i2c_ar_pkg::*;
  logic [BW-1:0] own_q;
  logic [BW-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      own_q <= '0;
      rd_q  <= '0;
    end else begin
      if (reg_wr && reg_sel == SEL_ADDR) own_q <= wr_data;
      if (!reg_rd)                       rd_q  <= '0;
      else if (reg_sel == SEL_STAT)      rd_q  <= stat_vec;
      else                               rd_q  <= own_q;
    end
  end

  assign own_reg = own_q;
  assign rd_data = rd_q;
endmodule

// File: rtl/i2c_addr_recog.sv
module i2c_addr_recog
  import i2c_ar_pkg::*;
#(
  parameter int BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_det,
  input  logic          byte_vld,
  input  logic [BW-1:0] byte_data,
  input  logic          slv_rx_mode,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic          reg_sel,
  input  logic [BW-1:0] wr_data,
  output logic [BW-1:0] rd_data,
  output logic          flag_addr,
  output logic          flag_gc,
  output logic          match_pulse
);
  logic [BW-1:0]        own_reg;
  logic                 hit_own, hit_gc;
  logic [NUM_FLAGS-1:0] set_vec, flag_vec;
  logic [BW-1:0]        stat_vec;
  logic                 stat_rd, stat_wr;
  logic                 match_q;

  i2c_ar_regs #(.BW(BW)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
    .wr_data(wr_data), .stat_vec(stat_vec), .own_reg(own_reg), .rd_data(rd_data)
  );

  i2c_ar_frame #(.BW(BW)) u_frame (
    .clk(clk), .rst(rst), .start_det(start_det), .byte_vld(byte_vld),
    .byte_data(byte_data), .own_addr(own_reg[BW-1:1]),
    .fmt_sync(own_reg[FMT_BIT]), .slv_rx_mode(slv_rx_mode),
    .hit_own(hit_own), .hit_gc(hit_gc)
  );

  always_comb begin
    stat_rd                = reg_rd && (reg_sel == SEL_STAT);
    stat_wr                = reg_wr && (reg_sel == SEL_STAT);
    set_vec                = '0;
    set_vec[ST_ADDR_BIT]   = hit_own || hit_gc;
    set_vec[ST_GC_BIT]     = hit_gc;
    stat_vec               = '0;
    stat_vec[NUM_FLAGS-1:0] = flag_vec;
  end

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    i2c_ar_flag u_flag (
      .clk(clk), .rst(rst), .set_req(set_vec[i]), .stat_rd(stat_rd),
      .stat_wr(stat_wr), .wr_bit(wr_data[i]), .flag(flag_vec[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) match_q <= 1'b0;
    else     match_q <= hit_own || hit_gc;
  end

  assign flag_addr   = flag_vec[ST_ADDR_BIT];
  assign flag_gc     = flag_vec[ST_GC_BIT];
  assign match_pulse = match_q;
endmodule

// File: rtl/i2c_addr_recog_chk.sv
module i2c_addr_recog_chk (
  input logic       clk,
  input logic       rst,
  input logic       slv_rx_mode,
  input logic       reg_wr,
  input logic       reg_sel,
  input logic [7:0] wr_data,
  input logic       flag_addr,
  input logic       flag_gc,
  input logic       match_pulse,
  input logic       fmt_sync
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!flag_addr && !flag_gc && !match_pulse));

  assert_gc_sets_addr_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_gc) |-> flag_addr);

  assert_pulse_with_flag_R4: assert property (@(posedge clk) disable iff (rst)
    match_pulse |-> flag_addr);

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    match_pulse |=> !match_pulse);

  assert_no_set_when_off_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_addr) |-> (!$past(fmt_sync) && $past(slv_rx_mode)));

  assert_clear_only_by_write0_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_addr) |-> $past(reg_wr && reg_sel && !wr_data[1]));

  assert_gc_clear_only_by_write0_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_gc) |-> $past(reg_wr && reg_sel && !wr_data[0]));
endmodule

bind i2c_addr_recog i2c_addr_recog_chk u_chk (
  .clk(clk), .rst(rst), .slv_rx_mode(slv_rx_mode), .reg_wr(reg_wr),
  .reg_sel(reg_sel), .wr_data(wr_data), .flag_addr(flag_addr),
  .flag_gc(flag_gc), .match_pulse(match_pulse), .fmt_sync(own_reg[0])
);

// File: tb/i2c_addr_recog_bench.sv
`timescale 1ns/1ps
module i2c_addr_recog_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_det = 1'b0, byte_vld = 1'b0, slv_rx_mode = 1'b0;
  logic [7:0] byte_data = 8'h00, wr_data = 8'h00;
  logic       reg_wr = 1'b0, reg_rd = 1'b0, reg_sel = 1'b0;
  logic [7:0] rd_data;
  logic       flag_addr, flag_gc, match_pulse;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit started = 0;

  // reference model state
  int m_sar = 0, m_rd = 0;
  bit m_fa = 0, m_fg = 0, m_arma = 0, m_armg = 0, m_pend = 0, m_match = 0;

  always #2.5 clk = ~clk;

  i2c_addr_recog u_i2c_addr_recog (
    .clk(clk), .rst(rst), .start_det(start_det), .byte_vld(byte_vld),
    .byte_data(byte_data), .slv_rx_mode(slv_rx_mode), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_sel(reg_sel), .wr_data(wr_data), .rd_data(rd_data),
    .flag_addr(flag_addr), .flag_gc(flag_gc), .match_pulse(match_pulse)
  );

  always @(posedge clk) begin
    bit ev, own, gc, nfa, nfg, narma, narmg, swr, srd;
    started = 1;
    if (rst) begin
      m_sar = 0; m_rd = 0; m_fa = 0; m_fg = 0;
      m_arma = 0; m_armg = 0; m_pend = 0; m_match = 0;
    end else begin
      ev   = byte_vld && m_pend && !start_det && (m_sar % 2 == 0) && slv_rx_mode;
      own  = ev && (int'(byte_data) / 2 == m_sar / 2);
      gc   = ev && (byte_data == 8'h00);
      swr  = reg_wr && reg_sel;
      srd  = reg_rd && reg_sel;
      m_rd = !reg_rd ? 0 : (reg_sel ? (m_fa * 2 + m_fg) : m_sar);
      nfa  = (own || gc) ? 1 : ((swr && !wr_data[1] && m_arma) ? 0 : m_fa);
      nfg  = gc ? 1 : ((swr && !wr_data[0] && m_armg) ? 0 : m_fg);
      narma = !m_fa ? 0 : (swr ? 0 : (srd ? 1 : m_arma));
      narmg = !m_fg ? 0 : (swr ? 0 : (srd ? 1 : m_armg));
      m_fa = nfa; m_fg = nfg; m_arma = narma; m_armg = narmg;
      if (reg_wr && !reg_sel) m_sar = wr_data;
      if (start_det) m_pend = 1; else if (byte_vld) m_pend = 0;
      m_match = own || gc;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // clock-by-clock comparison against the model
  always @(negedge clk) begin
    if (started) begin
      cyc++;
      chk("R4 flag_addr", flag_addr, m_fa);
      chk("R5 flag_gc", flag_gc, m_fg);
      chk("R4 match_pulse", match_pulse, m_match);
      chk("R7 rd_data", rd_data, m_rd);
      if (cyc > 20000) begin
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    start_det = 0; byte_vld = 0; reg_wr = 0; reg_rd = 0;
  endtask
  task automatic do_start(); start_det = 1; tick(); endtask
  task automatic do_byte(input logic [7:0] b); byte_vld = 1; byte_data = b; tick(); endtask
  task automatic do_wr(input logic s, input logic [7:0] d);
    reg_wr = 1; reg_sel = s; wr_data = d; tick();
  endtask
  task automatic do_rd(input logic s); reg_rd = 1; reg_sel = s; tick(); endtask

  initial begin
    @(negedge clk);
    chk("R1 flags in reset", {flag_addr, flag_gc, match_pulse}, 0);
    tick(); tick();
    rst = 0;
    tick();
    chk("R1 flags after reset", {flag_addr, flag_gc, match_pulse}, 0);
    do_rd(0);
    chk("R1 addr reg after reset", rd_data, 8'h00);
    do_wr(0, 8'h54);
    do_rd(0);
    chk("R2 addr reg readback", rd_data, 8'h54);
    tick();
    chk("R2 rd_data idle zero", rd_data, 0);

    slv_rx_mode = 1;
    do_start(); do_byte(8'h55);
    chk("R4 own match flag", flag_addr, 1);
    chk("R4 match pulse", match_pulse, 1);
    chk("R4 no gc", flag_gc, 0);
    tick();
    chk("R4 pulse one cycle", match_pulse, 0);
    do_rd(1);
    chk("R7 status byte", rd_data, 8'h02);
    do_wr(1, 8'h00);
    chk("R8 clear after read", flag_addr, 0);

    do_start(); do_byte(8'h54);
    do_wr(1, 8'h00);
    chk("R8 no clear without read", flag_addr, 1);
    do_rd(1); do_wr(1, 8'h02);
    chk("R9 write 1 no effect", flag_addr, 1);
    do_wr(1, 8'h00);
    chk("R10 arm consumed", flag_addr, 1);
    do_rd(1); do_wr(1, 8'h00);
    chk("R8 cleared", flag_addr, 0);

    do_start(); do_byte(8'h12); do_byte(8'h54);
    chk("R3 later byte ignored", flag_addr, 0);
    do_start(); do_byte(8'h54);
    chk("R3 repeated start rearms", flag_addr, 1);
    do_rd(1); do_wr(1, 8'h00);
    start_det = 1; byte_vld = 1; byte_data = 8'h54; tick();
    chk("R3 byte with start ignored", flag_addr, 0);
    do_byte(8'h54);
    chk("R3 still armed after", flag_addr, 1);
    do_rd(1); do_wr(1, 8'h00);

    do_start(); do_byte(8'h00);
    chk("R5 gc both flags", {flag_addr, flag_gc, match_pulse}, 3'b111);
    do_rd(1);
    chk("R7 status gc", rd_data, 8'h03);
    do_wr(1, 8'h00);
    chk("R8 both cleared", {flag_addr, flag_gc}, 0);
    do_start(); do_byte(8'h01);
    chk("R5 0x01 not gc", {flag_addr, flag_gc, match_pulse}, 0);

    slv_rx_mode = 0;
    do_start(); do_byte(8'h54);
    chk("R6 not rx mode", {flag_addr, match_pulse}, 0);
    slv_rx_mode = 1;
    do_wr(0, 8'h55);
    do_start(); do_byte(8'h54);
    chk("R6 sync format own", {flag_addr, match_pulse}, 0);
    do_start(); do_byte(8'h00);
    chk("R6 sync format gc", {flag_addr, flag_gc}, 0);
    do_wr(0, 8'h54);

    do_start(); do_byte(8'h54);
    do_rd(1);
    do_start();
    byte_vld = 1; byte_data = 8'h54; reg_wr = 1; reg_sel = 1; wr_data = 8'h00; tick();
    chk("R9 set beats clear", flag_addr, 1);
    do_rd(1); do_wr(1, 8'h00);

    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 99);
      int pick = $urandom_range(0, 3);
      logic [7:0] b = (pick == 0) ? 8'h54 : (pick == 1) ? 8'h55 :
                      (pick == 2) ? 8'h00 : 8'($urandom_range(0, 3));
      slv_rx_mode = ($urandom_range(0, 9) != 0);
      start_det   = (r < 15);
      byte_vld    = (r >= 10 && r < 45);
      byte_data   = b;
      reg_rd      = (r >= 45 && r < 65);
      reg_wr      = (r >= 60 && r < 80);
      reg_sel     = ($urandom_range(0, 7) != 0);
      wr_data     = reg_sel ? 8'($urandom_range(0, 3)) :
                    (($urandom_range(0, 5) == 0) ? 8'h55 : 8'h54);
      tick();
    end
    tick();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule